// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps an asynchronous DRAM alive. Out of reset it first holds the memory quiet for a power-up pause. It then runs a fixed number of wake-up refresh cycles and raises `init_done`. From then on a free-running interval timer requests one refresh per interval. The block drives the RAS, CAS and W strobes for each refresh itself. It shares the memory pins with an access sequencer through a request/grant pair, and while `acc_gnt` is high the sequencer owns the pins.

Two refresh styles are available. In the default style CAS is lowered ahead of RAS, the address is not used and the data pins stay released. With `mode_row_only` high, CAS stays high instead, and a row counter inside the block is put on `ram_row` and strobed by RAS. The counter advances once per such cycle and wraps at 2^ROW_BITS.

When a long access holds the bus, the refreshes that fall due are counted up to a limit. Once the bus is released they are all issued back to back, and only then is a new access granted.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted and after it is released, RAS, CAS and W are high and `init_done`/`acc_gnt` are low; no RAS falling edge occurs within PAUSE_CYC cycles of reset release.
- R2: After the pause, exactly WAKE_CNT refresh cycles are issued and then `init_done` rises; `acc_gnt` stays low before `init_done` even with `acc_req` held high.
- R3: In the CAS-first style (`mode_row_only`=0), CAS is low for at least T_CSR cycles before RAS falls and stays low while RAS is low.
- R4: W (`ram_we_n`) stays high at every cycle, so a refresh never selects the test mode.
- R5: Every refresh holds RAS low for exactly T_RAS cycles.
- R6: Between RAS rising and the next CAS falling edge, CAS stays high for at least max(T_RP, T_RPC) cycles, including back-to-back refreshes.
- R7: With the bus idle, successive refresh RAS falling edges are exactly INTERVAL_CYC cycles apart.
- R8: In the row style (`mode_row_only`=1), CAS stays high, `ram_row_oe` is high while RAS is low, and `ram_row` is stable across the RAS rising edge. The row is 0 for the first row-style refresh after reset, is not moved by CAS-first refreshes, and steps by +1 modulo 2^ROW_BITS per row-style refresh.
- R9: While `acc_gnt` is high, the block keeps RAS and CAS high, and refreshes that fall due are held pending.
- R10: After the grant is released, all pending refreshes are issued back to back before any new grant. Their number equals the intervals that elapsed during the grant.
- R11: The pending count saturates at PEND_MAX, so at most PEND_MAX catch-up refreshes follow a long grant.
- R12: `acc_gnt` rises only when `acc_req` was high, initialisation is done, no refresh is pending or running. It falls on the clock after `acc_req` is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_row_only | input | 1 | 1 selects row-counter refresh, 0 selects CAS-first refresh |
| acc_req | input | 1 | Access sequencer asks for the memory pins (level) |
| acc_gnt | output | 1 | Access sequencer owns the memory pins |
| ref_busy | output | 1 | A refresh cycle is in progress |
| init_done | output | 1 | Power-up pause and wake-up refreshes complete |
| ram_ras_n | output | 1 | Row strobe, active low |
| ram_cas_n | output | 1 | Column strobe, active low |
| ram_we_n | output | 1 | Write strobe, held high |
| ram_row_oe | output | 1 | Block drives `ram_row` onto the address pins |
| ram_row | output | ROW_BITS | Refresh row address |

## Verification
The hardest state to reach from the ports is a saturated pending count. It needs a grant held across more intervals than PEND_MAX, with release timed so that the catch-up burst ends before the next tick. The stimulus waits for an observed refresh RAS fall, which fixes the timer phase. It then takes the grant and holds it for a whole number of intervals plus a short margin. Finally it drops and at once re-raises the request, and counts the RAS falls before the grant returns: two for a short hold, and PEND_MAX for a six-interval hold.

// File: rtl/drs_pkg.sv
`timescale 1ns/1ps
package drs_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_PRECH  = 2'd3
    } ref_phase_e;

    typedef enum logic {
        REF_CBR = 1'b0,
        REF_ROW = 1'b1
    } ref_kind_e;

    typedef enum logic [1:0] {
        BOOT_PAUSE = 2'd0,
        BOOT_WAKE  = 2'd1,
        BOOT_RUN   = 2'd2
    } boot_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic row_oe;
    } strobe_t;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Pin levels for one phase of a refresh cycle of the given style.
    function automatic strobe_t phase_strobes(ref_phase_e ph, ref_kind_e k);
        strobe_t s;
        s.ras_n  = 1'b1;
        s.cas_n  = 1'b1;
        s.we_n   = 1'b1;
        s.row_oe = 1'b0;
        case (ph)
            PH_SETUP: begin
                s.cas_n  = (k == REF_ROW);
                s.row_oe = (k == REF_ROW);
            end
            PH_ACTIVE: begin
                s.ras_n  = 1'b0;
                s.cas_n  = (k == REF_ROW);
                s.row_oe = (k == REF_ROW);
            end
            PH_PRECH: begin
                s.row_oe = (k == REF_ROW);
            end
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/drs_tick_gen.sv
`timescale 1ns/1ps
module drs_tick_gen #(
    parameter int unsigned INTERVAL = 1560
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int unsigned W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [W-1:0] LAST = W'(INTERVAL - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = en && (cnt_q == LAST);
endmodule

// File: rtl/drs_pend_ctr.sv
`timescale 1ns/1ps
module drs_pend_ctr #(
    parameter int unsigned PEND_MAX = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    output logic pending
);
    localparam int unsigned W = $clog2(PEND_MAX + 1);
    localparam logic [W-1:0] TOP = W'(PEND_MAX);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            case ({inc, dec})
                2'b10: if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
                2'b01: if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
                default: ;
            endcase
        end
    end

    assign pending = (cnt_q != '0);
endmodule

// File: rtl/drs_row_ctr.sv
`timescale 1ns/1ps
module drs_row_ctr #(
    parameter int unsigned ROW_BITS = 13
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                step,
    output logic [ROW_BITS-1:0] row
);
    always_ff @(posedge clk) begin
        if (rst) begin
            row <= '0;
        end else if (step) begin
            row <= row + 1'b1;
        end
    end
endmodule

// File: rtl/drs_cycle_fsm.sv
`timescale 1ns/1ps
module drs_cycle_fsm
    import drs_pkg::*;
#(
    parameter int unsigned T_SETUP_CBR = 1,
    parameter int unsigned T_SETUP_ROW = 1,
    parameter int unsigned T_ACT       = 5,
    parameter int unsigned T_PRE       = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  ref_kind_e kind,
    output strobe_t   pins,
    output logic      busy,
    output logic      row_step
);
    localparam int unsigned LMAX = max2(max2(T_SETUP_CBR, T_SETUP_ROW), max2(T_ACT, T_PRE));
    localparam int unsigned CW   = (LMAX > 1) ? $clog2(LMAX) : 1;

    ref_phase_e   phase_q;
    ref_kind_e    kind_q;
    logic [CW-1:0] cnt_q;
    logic         last;

    assign last = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            kind_q  <= REF_CBR;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: if (start) begin
                    kind_q  <= kind;
                    phase_q <= PH_SETUP;
                    cnt_q   <= (kind == REF_ROW) ? CW'(T_SETUP_ROW - 1) : CW'(T_SETUP_CBR - 1);
                end
                PH_SETUP: if (last) begin
                    phase_q <= PH_ACTIVE;
                    cnt_q   <= CW'(T_ACT - 1);
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
                PH_ACTIVE: if (last) begin
                    phase_q <= PH_PRECH;
                    cnt_q   <= CW'(T_PRE - 1);
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
                PH_PRECH: if (last) begin
                    phase_q <= PH_IDLE;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign pins     = phase_strobes(phase_q, kind_q);
    assign busy     = (phase_q != PH_IDLE);
    assign row_step = (phase_q == PH_PRECH) && last && (kind_q == REF_ROW);
endmodule

// File: rtl/dram_refresh_sched.sv
`timescale 1ns/1ps
module dram_refresh_sched
    import drs_pkg::*;
#(
    parameter int unsigned PAUSE_CYC    = 20000,
    parameter int unsigned WAKE_CNT     = 8,
    parameter int unsigned INTERVAL_CYC = 1560,
    parameter int unsigned ROW_BITS     = 13,
    parameter int unsigned PEND_MAX     = 8,
    parameter int unsigned T_CSR        = 1,
    parameter int unsigned T_ASR        = 1,
    parameter int unsigned T_RAS        = 5,
    parameter int unsigned T_RP         = 3,
    parameter int unsigned T_RPC        = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mode_row_only,
    input  logic                acc_req,
    output logic                acc_gnt,
    output logic                ref_busy,
    output logic                init_done,
    output logic                ram_ras_n,
    output logic                ram_cas_n,
    output logic                ram_we_n,
    output logic                ram_row_oe,
    output logic [ROW_BITS-1:0] ram_row
);
    localparam int unsigned T_PRE = max2(T_RP, T_RPC);
    localparam int unsigned PW    = (PAUSE_CYC > 1) ? $clog2(PAUSE_CYC) : 1;
    localparam int unsigned WW    = $clog2(WAKE_CNT + 1);

    boot_e         boot_q;
    logic [PW-1:0] pause_q;
    logic [WW-1:0] wake_q;
    logic          run;
    logic          busy;
    logic          tick;
    logic          pend_any;
    logic          wake_start;
    logic          run_start;
    logic          ref_start;
    logic          row_step;
    strobe_t       pins;
    ref_kind_e     kind_sel;

    assign run        = (boot_q == BOOT_RUN);
    assign kind_sel   = mode_row_only ? REF_ROW : REF_CBR;
    assign wake_start = (boot_q == BOOT_WAKE) && !busy && (wake_q != WW'(WAKE_CNT));
    assign run_start  = run && pend_any && !busy && !acc_gnt;
    assign ref_start  = wake_start || run_start;

    // Power-up: quiet pause, then the wake-up refresh burst.
    always_ff @(posedge clk) begin
        if (rst) begin
            boot_q  <= BOOT_PAUSE;
            pause_q <= '0;
            wake_q  <= '0;
        end else begin
            case (boot_q)
                BOOT_PAUSE: begin
                    if (pause_q == PW'(PAUSE_CYC - 1)) begin
                        boot_q <= BOOT_WAKE;
                    end else begin
                        pause_q <= pause_q + 1'b1;
                    end
                end
                BOOT_WAKE: begin
                    if (wake_start) begin
                        wake_q <= wake_q + 1'b1;
                    end
                    if ((wake_q == WW'(WAKE_CNT)) && !busy) begin
                        boot_q <= BOOT_RUN;
                    end
                end
                default: ;
            endcase
        end
    end

    // Bus ownership: held while requested, refresh has priority on hand-over.
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_gnt <= 1'b0;
        end else if (acc_gnt) begin
            acc_gnt <= acc_req;
        end else begin
            acc_gnt <= run && acc_req && !busy && !pend_any;
        end
    end

    drs_tick_gen #(
        .INTERVAL (INTERVAL_CYC)
    ) tick_i (
        .clk  (clk),
        .rst  (rst),
        .en   (run),
        .tick (tick)
    );

    drs_pend_ctr #(
        .PEND_MAX (PEND_MAX)
    ) pend_i (
        .clk     (clk),
        .rst     (rst),
        .inc     (tick),
        .dec     (run_start),
        .pending (pend_any)
    );

    drs_cycle_fsm #(
        .T_SETUP_CBR (T_CSR),
        .T_SETUP_ROW (T_ASR),
        .T_ACT       (T_RAS),
        .T_PRE       (T_PRE)
    ) cyc_i (
        .clk      (clk),
        .rst      (rst),
        .start    (ref_start),
        .kind     (kind_sel),
        .pins     (pins),
        .busy     (busy),
        .row_step (row_step)
    );

    drs_row_ctr #(
        .ROW_BITS (ROW_BITS)
    ) row_i (
        .clk  (clk),
        .rst  (rst),
        .step (row_step),
        .row  (ram_row)
    );

    assign init_done  = run;
    assign ref_busy   = busy;
    assign ram_ras_n  = pins.ras_n;
    assign ram_cas_n  = pins.cas_n;
    assign ram_we_n   = pins.we_n;
    assign ram_row_oe = pins.row_oe;
endmodule

// File: rtl/drs_sched_checker.sv
`timescale 1ns/1ps
module drs_sched_checker #(
    parameter int unsigned ROW_BITS = 13,
    parameter int unsigned T_RAS    = 5
) (
    input logic                clk,
    input logic                rst,
    input logic                acc_req,
    input logic                acc_gnt,
    input logic                init_done,
    input logic                ram_ras_n,
    input logic                ram_cas_n,
    input logic                ram_row_oe,
    input logic [ROW_BITS-1:0] ram_row
);
    logic [15:0] lo_run;

    always_ff @(posedge clk) begin
        if (rst || ram_ras_n) lo_run <= '0;
        else                  lo_run <= lo_run + 1'b1;
    end

    p_no_early_gnt_r2: assert property (@(posedge clk) disable iff (rst)
        !init_done |-> !acc_gnt);

    p_cbr_order_r3: assert property (@(posedge clk) disable iff (rst)
        ($fell(ram_ras_n) && !ram_row_oe) |-> ($past(!ram_cas_n) && !ram_cas_n));

    p_ras_width_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(ram_ras_n) |-> (lo_run == 16'(T_RAS)));

    p_row_cas_high_r8: assert property (@(posedge clk) disable iff (rst)
        ram_row_oe |-> ram_cas_n);

    p_row_stable_r8: assert property (@(posedge clk) disable iff (rst)
        ($rose(ram_ras_n) && ram_row_oe) |-> $stable(ram_row));

    p_gnt_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        acc_gnt |-> (ram_ras_n && ram_cas_n));

    p_gnt_req_r12: assert property (@(posedge clk) disable iff (rst)
        $rose(acc_gnt) |-> $past(acc_req));

    p_gnt_drop_r12: assert property (@(posedge clk) disable iff (rst)
        (acc_gnt && !acc_req) |=> !acc_gnt);
endmodule

bind dram_refresh_sched drs_sched_checker #(
    .ROW_BITS (ROW_BITS),
    .T_RAS    (T_RAS)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .acc_req    (acc_req),
    .acc_gnt    (acc_gnt),
    .init_done  (init_done),
    .ram_ras_n  (ram_ras_n),
    .ram_cas_n  (ram_cas_n),
    .ram_row_oe (ram_row_oe),
    .ram_row    (ram_row)
);

// File: tb/dram_refresh_sched_tb_top.sv
`timescale 1ns/1ps
module dram_refresh_sched_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PAUSE_CYC  = 50;
    localparam int WAKE_CNT   = 8;
    localparam int INTERVAL   = 80;
    localparam int ROW_BITS   = 3;
    localparam int PEND_MAX   = 4;
    localparam int T_CSR      = 2;
    localparam int T_ASR      = 1;
    localparam int T_RAS      = 4;
    localparam int T_RP       = 3;
    localparam int T_RPC      = 2;
    localparam int T_PRE      = (T_RP > T_RPC) ? T_RP : T_RPC;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_row_only = 1'b0;
    logic acc_req = 1'b0;
    logic acc_gnt, ref_busy, init_done, ram_ras_n, ram_cas_n, ram_we_n, ram_row_oe;
    logic [ROW_BITS-1:0] ram_row;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dram_refresh_sched #(
        .PAUSE_CYC (PAUSE_CYC), .WAKE_CNT (WAKE_CNT), .INTERVAL_CYC (INTERVAL),
        .ROW_BITS (ROW_BITS), .PEND_MAX (PEND_MAX), .T_CSR (T_CSR), .T_ASR (T_ASR),
        .T_RAS (T_RAS), .T_RP (T_RP), .T_RPC (T_RPC)
    ) dut_i (
        .clk (clk), .rst (rst), .mode_row_only (mode_row_only), .acc_req (acc_req),
        .acc_gnt (acc_gnt), .ref_busy (ref_busy), .init_done (init_done),
        .ram_ras_n (ram_ras_n), .ram_cas_n (ram_cas_n), .ram_we_n (ram_we_n),
        .ram_row_oe (ram_row_oe), .ram_row (ram_row)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Port monitor, sampled on the falling clock edge.
    int cyc = 0, rel_cyc = 0, falls = 0, n_cbr = 0, n_ro = 0;
    int first_fall = -1, last_fall = 0, last_spacing = 0;
    int ras_lo_run = 0, cas_lo_run = 0, cas_hi_run = 0, min_cas_hi = 1000;
    int csr_bad = 0, width_bad = 0, we_bad = 0, gnt_clash = 0, gnt_early = 0;
    int ro_cas_bad = 0, row_bad = 0, row_caps = 0, first_row = -1, prev_row = -1;
    bit wrap_seen = 0;
    logic prev_ras = 1'b1, prev_cas = 1'b1;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (prev_ras && !ram_ras_n) begin
                falls++;
                if (first_fall < 0) first_fall = cyc;
                last_spacing = cyc - last_fall;
                last_fall = cyc;
                if (!ram_cas_n) begin
                    n_cbr++;
                    if (cas_lo_run < T_CSR) csr_bad++;
                end else begin
                    n_ro++;
                end
            end
            if (!prev_ras && ram_ras_n) begin
                if (ras_lo_run != T_RAS) width_bad++;
                if (ram_row_oe) begin
                    row_caps++;
                    if (first_row < 0) first_row = int'(ram_row);
                    if (prev_row >= 0) begin
                        if (int'(ram_row) != (prev_row + 1) % (1 << ROW_BITS)) row_bad++;
                        if (prev_row == (1 << ROW_BITS) - 1 && ram_row == '0) wrap_seen = 1;
                    end
                    prev_row = int'(ram_row);
                end
            end
            if (prev_cas && !ram_cas_n && falls > 0 && cas_hi_run < min_cas_hi)
                min_cas_hi = cas_hi_run;
            if (!ram_we_n) we_bad++;
            if (acc_gnt && (!ram_ras_n || !ram_cas_n)) gnt_clash++;
            if (acc_gnt && !init_done) gnt_early++;
            if (ram_row_oe && !ram_cas_n) ro_cas_bad++;
        end
        ras_lo_run = ram_ras_n ? 0 : ras_lo_run + 1;
        cas_lo_run = ram_cas_n ? 0 : cas_lo_run + 1;
        cas_hi_run = ram_cas_n ? cas_hi_run + 1 : 0;
        prev_ras = ram_ras_n;
        prev_cas = ram_cas_n;
    end

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        acc_req = 1'b1;
        wait_cycles(4);
        check(ram_ras_n && ram_cas_n && ram_we_n, "R1 strobes idle in reset", {ram_ras_n, ram_cas_n, ram_we_n}, 7);
        check(!init_done, "R1 init_done low in reset", init_done, 0);
        check(!acc_gnt, "R1 no grant in reset", acc_gnt, 0);
        @(posedge clk); #1 rst = 1'b0;
        rel_cyc = cyc;
        wait_cycles(2);
        check(ram_ras_n && !init_done, "R1 idle after release", ram_ras_n, 1);
    endtask

    task automatic t_boot();
        int t = 0;
        while (!init_done && t < 2000) begin @(negedge clk); t++; end
        check(init_done, "R2 init_done reached", init_done, 1);
        check(first_fall - rel_cyc >= PAUSE_CYC, "R1 pause before first refresh", first_fall - rel_cyc, PAUSE_CYC);
        check(falls == WAKE_CNT, "R2 wake-up refresh count", falls, WAKE_CNT);
        check(gnt_early == 0, "R2 no grant before init_done", gnt_early, 0);
        t = 0;
        while (!acc_gnt && t < 20) begin @(negedge clk); t++; end
        check(acc_gnt, "R12 grant after init", acc_gnt, 1);
        @(posedge clk); #1 acc_req = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(!acc_gnt, "R12 grant drops after release", acc_gnt, 0);
    endtask

    task automatic t_cbr();
        int base = falls;
        int t = 0;
        while (falls < base + 3 && t < 400) begin @(negedge clk); t++; end
        check(falls >= base + 3, "R7 refreshes keep coming", falls - base, 3);
        check(last_spacing == INTERVAL, "R7 refresh spacing", last_spacing, INTERVAL);
        check(csr_bad == 0 && n_cbr == falls, "R3 CAS before RAS", csr_bad, 0);
        check(width_bad == 0, "R5 RAS low width", width_bad, 0);
        check(we_bad == 0, "R4 W held high", we_bad, 0);
    endtask

    task automatic t_row();
        int t = 0;
        mode_row_only = 1'b1;
        while (n_ro < 10 && t < 12 * INTERVAL) begin @(negedge clk); t++; end
        mode_row_only = 1'b0;
        check(n_ro >= 10, "R8 row-style refreshes issued", n_ro, 10);
        check(first_row == 0, "R8 first row after reset", first_row, 0);
        check(row_bad == 0, "R8 row step by one", row_bad, 0);
        check(wrap_seen, "R8 row wraps to zero", wrap_seen, 1);
        check(ro_cas_bad == 0, "R8 CAS high in row style", ro_cas_bad, 0);
    endtask

    task automatic t_defer(input int hold, input int expect_n, input string req);
        int base = falls;
        int t = 0;
        int fall_at, clash0, got;
        while (falls == base && t < 2 * INTERVAL) begin @(negedge clk); t++; end
        fall_at = last_fall;
        @(posedge clk); #1 acc_req = 1'b1;
        t = 0;
        while (!acc_gnt && t < 50) begin @(negedge clk); t++; end
        clash0 = gnt_clash;
        base = falls;
        while (cyc < fall_at + hold * INTERVAL + 10) @(negedge clk);
        check(falls == base && gnt_clash == clash0, "R9 no refresh under grant", falls - base, 0);
        @(posedge clk); #1 acc_req = 1'b0;
        @(posedge clk); #1 acc_req = 1'b1;
        base = falls;
        t = 0;
        @(negedge clk);
        while (!acc_gnt && t < 200) begin @(negedge clk); t++; end
        got = falls - base;
        check(got == expect_n, req, got, expect_n);
        check(min_cas_hi >= T_PRE, "R6 precharge between refreshes", min_cas_hi, T_PRE);
        @(posedge clk); #1 acc_req = 1'b0;
        wait_cycles(3);
    endtask

    initial begin
        t_reset();
        t_boot();
        t_cbr();
        t_row();
        t_defer(2, 2, "R10 catch-up burst count");
        t_defer(6, PEND_MAX, "R11 pending saturates");
        check(we_bad == 0 && width_bad == 0, "R4 R5 final strobe audit", we_bad + width_bad, 0);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
        finish_run();
    end
endmodule